// File: doc/BRIEF.md
# O-QPSK Symbol-to-Chip Spreader

This block is the transmit end of a 2.4 GHz low-rate personal-area-network physical layer that uses offset-QPSK direct-sequence spreading. A start pulse launches a frame. The block first sends a run of all-zero synchronisation symbols. It then sends the two delimiter symbols and the two symbols of the length header, which it builds from the latched frame length. After that it pulls the frame body from a first-word-fall-through transmit FIFO one nibble at a time. Each 4-bit symbol becomes a 32-chip spreading code, and the chips leave on a single serial line at one chip per clock of the transmit chip clock.

The chip code is held as an interleaved I set (even chips) and Q set (odd chips). The serial line alternates between the two sets, which is the form an MSK-equivalent modulator expects. Frame-check bytes are not computed here: they are expected in the FIFO as the last bytes of the body. If the FIFO runs dry while the body is being sent, the frame is cut short and an error pulse is raised.

Top module: `oqpsk_chip_spreader`

## Requirements
- R1: After reset is asserted, busy, done, underflow, fifo_rd and chip_out are all 0 from the first clock edge with rst_n low.
- R2: The frame opens with PREAMBLE_SYMS copies of symbol 0.
- R3: The delimiter byte SFD_BYTE (default 0xA7) follows, low nibble first, so symbol 7 is sent and then symbol 10.
- R4: Next comes the header byte, formed as a zero reserved bit above the 7-bit frame length. Its low nibble is sent first, then its high nibble.
- R5: Symbol 0 spreads to the chip sequence 11011001110000110101001000101110, written c0 first. Symbol n (1 to 7) is that sequence rotated toward higher chip index by 4n positions. Symbol n+8 is symbol n with every odd-indexed chip inverted. Chips leave in the order c0 to c31, one per clock.
- R6: Body nibbles are sent in FIFO order, two per length unit, so the total body is 2·frame_len symbols. fifo_rd is high for exactly one cycle per nibble, during the last chip of the preceding symbol, and fifo_rdata is taken in that cycle.
- R7: busy is high from the cycle after an accepted start until the last chip has been sent. done is a one-cycle pulse in the cycle after the last chip. chip_out is 0 while busy is low.
- R8: With frame_len 0 the frame ends after the header and no FIFO read takes place.
- R9: If the FIFO is empty when a body nibble is needed, underflow pulses for one cycle, busy falls at the same edge, and done is not raised for that frame.
- R10: start is ignored while busy is high. frame_len is sampled only when a start is accepted.
- R11: fifo_rd is never high while fifo_empty is high or busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit chip clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a frame when idle |
| frame_len | input | LEN_W | Body length in bytes, sampled at start |
| fifo_rdata | input | 4 | Head nibble of the transmit FIFO |
| fifo_empty | input | 1 | Transmit FIFO has no nibble |
| fifo_rd | output | 1 | Consume the head nibble |
| chip_out | output | 1 | Serial chip stream |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| underflow | output | 1 | One-cycle FIFO-underflow abort pulse |

## Verification
The bench builds the block with its defaults: eight preamble symbols, a seven-bit length and a 0xA7 delimiter. These make a full 127-byte frame of 266 symbols short enough to send completely. With a body pattern whose nibbles step through all sixteen values, every spreading code is compared chip by chip. The defaults also put the zero-length case, an underflow partway through the body, a start and a length change during a frame, and a reset during a frame within easy reach.

// File: rtl/oqpsk_tx_pkg.sv
// Shared constants and types for the chip spreader.
// Assumes the 32-chip spreading code of the 2.4 GHz O-QPSK physical layer.
package oqpsk_tx_pkg;
    localparam int CHIPS_PER_SYM = 32;
    localparam int SYM_W         = 4;
    localparam int NUM_SYMS      = 1 << SYM_W;
    localparam int HALF_CHIPS    = CHIPS_PER_SYM / 2;
    localparam int IDX_W         = $clog2(CHIPS_PER_SYM);

    // Base code of symbol 0; bit 31 holds c0, bit 0 holds c31.
    localparam logic [CHIPS_PER_SYM-1:0] SYM0_CODE = 32'b11011001110000110101001000101110;

    typedef enum logic [1:0] {PH_PRE, PH_SFD, PH_PHR, PH_DATA} phase_t;

    // Chip vector of symbol n, indexed so that bit i is chip c_i.
    function automatic logic [CHIPS_PER_SYM-1:0] code_of(input int n);
        logic [CHIPS_PER_SYM-1:0] r;
        int src;
        for (int i = 0; i < CHIPS_PER_SYM; i++) begin
            src  = (i - 4 * (n % 8) + CHIPS_PER_SYM) % CHIPS_PER_SYM;
            r[i] = SYM0_CODE[CHIPS_PER_SYM-1-src];
            if (n >= 8 && (i % 2) == 1) r[i] = ~r[i];
        end
        return r;
    endfunction
endpackage

// File: rtl/oqpsk_chip_lut.sv
// Maps a 4-bit symbol to its chip code, split into the I set (even chips)
// and the Q set (odd chips). Purely combinational; codes are built at
// elaboration from the package function.
module oqpsk_chip_lut
    import oqpsk_tx_pkg::*;
(
    input  logic [SYM_W-1:0]      sym,
    output logic [HALF_CHIPS-1:0] i_set,
    output logic [HALF_CHIPS-1:0] q_set
);
    logic [CHIPS_PER_SYM-1:0] codes [NUM_SYMS];
    logic [CHIPS_PER_SYM-1:0] sel_code;

    // One constant code per symbol value.
    for (genvar g = 0; g < NUM_SYMS; g++) begin : g_code
        assign codes[g] = code_of(g);
    end

    assign sel_code = codes[sym];

    // Split interleaved chips into the two quadrature sets.
    for (genvar k = 0; k < HALF_CHIPS; k++) begin : g_split
        assign i_set[k] = sel_code[2*k];
        assign q_set[k] = sel_code[2*k+1];
    end
endmodule

// File: rtl/oqpsk_chip_ser.sv
// Serialises one symbol: chip index bit 0 picks Q (odd) or I (even), the
// upper index bits pick the position within that set. Output held low
// when not enabled.
module oqpsk_chip_ser
    import oqpsk_tx_pkg::*;
(
    input  logic                  en,
    input  logic [IDX_W-1:0]      idx,
    input  logic [HALF_CHIPS-1:0] i_set,
    input  logic [HALF_CHIPS-1:0] q_set,
    output logic                  chip
);
    // Interleave I and Q chips into one line.
    always_comb begin
        if (!en)         chip = 1'b0;
        else if (idx[0]) chip = q_set[idx[IDX_W-1:1]];
        else             chip = i_set[idx[IDX_W-1:1]];
    end
endmodule

// File: rtl/oqpsk_sym_seq.sv
// Frame sequencer: from the current phase and count, decides which symbol
// follows, whether it must come from the FIFO, and whether the frame ends.
// Assumes PREAMBLE_SYMS >= 1 and LEN_W <= 7.
module oqpsk_sym_seq
    import oqpsk_tx_pkg::*;
#(
    parameter int         PREAMBLE_SYMS = 8,
    parameter int         LEN_W         = 7,
    parameter logic [7:0] SFD_BYTE      = 8'hA7,
    parameter int         CNT_W         = 8
) (
    input  phase_t           phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [LEN_W-1:0] len_q,
    input  logic [SYM_W-1:0] fifo_nib,
    output phase_t           nxt_phase,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic [SYM_W-1:0] nxt_sym,
    output logic             nxt_fifo,
    output logic             nxt_last
);
    localparam int PHR_PAD = 8 - LEN_W;

    logic [7:0]       phr_byte;
    logic [CNT_W-1:0] data_last;

    assign phr_byte  = {{PHR_PAD{1'b0}}, len_q};
    assign data_last = CNT_W'({len_q, 1'b0}) - CNT_W'(1);

    // Next-symbol selection per frame phase.
    always_comb begin
        nxt_phase = phase;
        nxt_cnt   = cnt + CNT_W'(1);
        nxt_sym   = '0;
        nxt_fifo  = 1'b0;
        nxt_last  = 1'b0;
        unique case (phase)
            PH_PRE: begin
                if (cnt == CNT_W'(PREAMBLE_SYMS - 1)) begin
                    nxt_phase = PH_SFD;
                    nxt_cnt   = '0;
                    nxt_sym   = SFD_BYTE[3:0];
                end
            end
            PH_SFD: begin
                if (cnt == '0) begin
                    nxt_sym = SFD_BYTE[7:4];
                end else begin
                    nxt_phase = PH_PHR;
                    nxt_cnt   = '0;
                    nxt_sym   = phr_byte[3:0];
                end
            end
            PH_PHR: begin
                if (cnt == '0) begin
                    nxt_sym = phr_byte[7:4];
                end else if (len_q == '0) begin
                    nxt_last = 1'b1;
                end else begin
                    nxt_phase = PH_DATA;
                    nxt_cnt   = '0;
                    nxt_sym   = fifo_nib;
                    nxt_fifo  = 1'b1;
                end
            end
            PH_DATA: begin
                if (cnt == data_last) begin
                    nxt_last = 1'b1;
                end else begin
                    nxt_sym  = fifo_nib;
                    nxt_fifo = 1'b1;
                end
            end
            default: nxt_last = 1'b1;
        endcase
    end
endmodule

// File: rtl/oqpsk_chip_spreader.sv
// Top of the transmit spreader. Holds the frame state (phase, symbol count,
// current symbol, chip index), advances one chip per clock, and loads the
// next symbol on the last chip of each symbol. The FIFO is first-word-fall-
// through: fifo_rdata is valid whenever fifo_empty is low.
module oqpsk_chip_spreader
    import oqpsk_tx_pkg::*;
#(
    parameter int         PREAMBLE_SYMS = 8,
    parameter int         LEN_W         = 7,
    parameter logic [7:0] SFD_BYTE      = 8'hA7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [3:0]       fifo_rdata,
    input  logic             fifo_empty,
    output logic             fifo_rd,
    output logic             chip_out,
    output logic             busy,
    output logic             done,
    output logic             underflow
);
    localparam int PRE_W = $clog2(PREAMBLE_SYMS + 1);
    localparam int CNT_W = (LEN_W + 1 > PRE_W) ? LEN_W + 1 : PRE_W;

    phase_t              phase_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [SYM_W-1:0]    sym_q;
    logic [IDX_W-1:0]    idx_q;
    logic [LEN_W-1:0]    len_q;
    phase_t              nxt_phase;
    logic [CNT_W-1:0]    nxt_cnt;
    logic [SYM_W-1:0]    nxt_sym;
    logic                nxt_fifo;
    logic                nxt_last;
    logic                last_chip;
    logic [HALF_CHIPS-1:0] i_set;
    logic [HALF_CHIPS-1:0] q_set;

    assign last_chip = (idx_q == IDX_W'(CHIPS_PER_SYM - 1));

    oqpsk_sym_seq #(
        .PREAMBLE_SYMS(PREAMBLE_SYMS),
        .LEN_W        (LEN_W),
        .SFD_BYTE     (SFD_BYTE),
        .CNT_W        (CNT_W)
    ) u_seq (
        .phase    (phase_q),
        .cnt      (cnt_q),
        .len_q    (len_q),
        .fifo_nib (fifo_rdata),
        .nxt_phase(nxt_phase),
        .nxt_cnt  (nxt_cnt),
        .nxt_sym  (nxt_sym),
        .nxt_fifo (nxt_fifo),
        .nxt_last (nxt_last)
    );

    oqpsk_chip_lut u_lut (
        .sym  (sym_q),
        .i_set(i_set),
        .q_set(q_set)
    );

    oqpsk_chip_ser u_ser (
        .en   (busy),
        .idx  (idx_q),
        .i_set(i_set),
        .q_set(q_set),
        .chip (chip_out)
    );

    // Pop the FIFO on the last chip of the symbol preceding a body nibble.
    assign fifo_rd = busy && last_chip && !nxt_last && nxt_fifo && !fifo_empty;

    // Frame state: accept start, step chips, load symbols, end or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            underflow <= 1'b0;
            phase_q   <= PH_PRE;
            cnt_q     <= '0;
            sym_q     <= '0;
            idx_q     <= '0;
            len_q     <= '0;
        end else begin
            done      <= 1'b0;
            underflow <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    phase_q <= PH_PRE;
                    cnt_q   <= '0;
                    sym_q   <= '0;
                    idx_q   <= '0;
                    len_q   <= frame_len;
                end
            end else if (!last_chip) begin
                idx_q <= idx_q + IDX_W'(1);
            end else if (nxt_last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (nxt_fifo && fifo_empty) begin
                busy      <= 1'b0;
                underflow <= 1'b1;
            end else begin
                phase_q <= nxt_phase;
                cnt_q   <= nxt_cnt;
                sym_q   <= nxt_sym;
                idx_q   <= '0;
            end
        end
    end
endmodule

// File: rtl/oqpsk_chip_spreader_chk.sv
// Port-level property checker for the spreader, bound to every instance.
module oqpsk_chip_spreader_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic chip_out,
    input logic busy,
    input logic done,
    input logic underflow
);
    AST_RD_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (!fifo_empty && busy)); // R11
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!chip_out && !fifo_rd)); // R7
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R7
    AST_UNDERFLOW_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (!busy && !done && $past(busy))); // R9
    AST_UNDERFLOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !underflow); // R9
endmodule

bind oqpsk_chip_spreader oqpsk_chip_spreader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fifo_empty(fifo_empty),
    .fifo_rd   (fifo_rd),
    .chip_out  (chip_out),
    .busy      (busy),
    .done      (done),
    .underflow (underflow)
);

// File: tb/test_oqpsk_chip_spreader.sv
module test_oqpsk_chip_spreader;
    localparam int PRE = 8;
    localparam int LW  = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] frame_len = '0;
    logic [3:0]    fifo_rdata;
    logic          fifo_empty;
    logic          fifo_rd;
    logic          chip_out;
    logic          busy;
    logic          done;
    logic          underflow;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    // FIFO model: first-word-fall-through, popped by fifo_rd.
    logic [3:0] q_mem [0:511];
    int ptr = 0;
    int base = 0;
    int avail = 0;
    always_ff @(posedge clk) if (fifo_rd) ptr <= ptr + 1;
    assign fifo_empty = (ptr - base) >= avail;
    assign fifo_rdata = q_mem[(ptr - base) & 511];

    oqpsk_chip_spreader #(.PREAMBLE_SYMS(PRE), .LEN_W(LW), .SFD_BYTE(8'hA7)) i_oqpsk_chip_spreader (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .chip_out(chip_out), .busy(busy), .done(done), .underflow(underflow)
    );

    // Table: len, seed, nibbles available, expected symbol count.
    localparam int CASES [4][4] = '{
        '{1,  8'h3C, 2,  14},
        '{3,  8'hF0, 6,  18},
        '{16, 8'h10, 32, 44},
        '{5,  8'h96, 10, 22}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_chip(input int sym, input int i);
        logic [31:0] b0 = 32'b11011001110000110101001000101110;
        int j = (i - 4 * (sym % 8) + 32) % 32;
        bit c = b0[31 - j];
        if (sym >= 8 && (i % 2) == 1) c = ~c;
        return c;
    endfunction

    function automatic int body_byte(input int seed, input int k);
        return (seed + k * 17) & 255;
    endfunction

    function automatic int exp_sym(input int s, input int len, input int seed);
        int k;
        if (s < PRE) return 0;
        if (s == PRE) return 7;
        if (s == PRE + 1) return 10;
        if (s == PRE + 2) return len & 15;
        if (s == PRE + 3) return len >> 4;
        k = s - PRE - 4;
        if (k % 2 == 1) return body_byte(seed, k / 2) >> 4;
        return body_byte(seed, k / 2) & 15;
    endfunction

    task automatic run_frame(input int len, input int seed, input int navail,
                             input int nsym_tab, input bit mid);
        int nsym = PRE + 4 + 2 * len;
        bit uf = navail < 2 * len;
        int nout = uf ? PRE + 4 + navail : nsym;
        string req;
        logic [31:0] gw, ew;
        chk(nsym == nsym_tab, "R6", "table symbol count", nsym, nsym_tab);
        for (int k = 0; k < len; k++) begin
            q_mem[2*k]   = 4'(body_byte(seed, k));
            q_mem[2*k+1] = 4'(body_byte(seed, k) >> 4);
        end
        base  = ptr;
        avail = navail;
        @(negedge clk);
        frame_len = LW'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        frame_len = ~LW'(len);
        chk(busy === 1'b1, "R7", "busy after start", busy, 1);
        for (int s = 0; s < nout; s++) begin
            int es = exp_sym(s, len, seed);
            for (int i = 0; i < 32; i++) begin
                gw[i] = chip_out;
                ew[i] = exp_chip(es, i);
                if (mid && s == 3 && i == 0) begin
                    start = 1'b1;
                    frame_len = '0;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
            end
            if (s < PRE) req = "R2 R5";
            else if (s < PRE + 2) req = "R3 R5";
            else if (s < PRE + 4) req = "R4 R5 R10";
            else req = "R6 R5";
            chk(gw === ew, req, $sformatf("symbol %0d chips", s), gw, ew);
        end
        if (uf) begin
            chk(underflow === 1'b1, "R9", "underflow pulse", underflow, 1);
            chk(busy === 1'b0 && done === 1'b0, "R9", "abort busy/done",
                {busy, done}, 0);
        end else begin
            chk(done === 1'b1 && busy === 1'b0, "R7", "done at end",
                {done, busy}, 2'b10);
            chk(underflow === 1'b0, "R9", "no underflow", underflow, 0);
        end
        chk(ptr - base == (uf ? navail : 2 * len), len == 0 ? "R8" : "R6",
            "fifo reads", ptr - base, uf ? navail : 2 * len);
        @(negedge clk);
        chk(done === 1'b0 && underflow === 1'b0, "R7", "pulse ends",
            {done, underflow}, 0);
        if (mid) begin
            repeat (40) @(negedge clk);
            chk(busy === 1'b0 && ptr - base == 2 * len, "R10",
                "start while busy ignored", busy, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, done, underflow, chip_out, fifo_rd} === 5'b0, "R1",
            "outputs in reset", {busy, done, underflow, chip_out, fifo_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, underflow, chip_out} === 4'b0, "R1",
            "idle after reset", {busy, done, underflow, chip_out}, 0);

        for (int c = 0; c < 4; c++)
            run_frame(CASES[c][0], CASES[c][1], CASES[c][2], CASES[c][3], 1'b0);

        // R8: zero length stops after the header.
        run_frame(0, 8'h00, 0, PRE + 4, 1'b0);
        // R9: FIFO runs dry after three body nibbles.
        run_frame(2, 8'h5A, 3, PRE + 8, 1'b0);
        // R10: start and a length change during a frame.
        run_frame(2, 8'hC3, 4, PRE + 8, 1'b1);
        // Longest frame.
        run_frame(127, 8'h21, 254, PRE + 258, 1'b0);

        // R1: reset during a frame.
        base = ptr;
        avail = 8;
        @(negedge clk);
        frame_len = 7'd4;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy, done, underflow, chip_out, fifo_rd} === 5'b0, "R1",
            "reset mid-frame", {busy, done, underflow, chip_out, fifo_rd}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(busy === 1'b0, "R1", "idle after mid-frame reset", busy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule